// File: doc/BRIEF.md
# Segmented Serial Shift Chain with Reversible Taps

This block is a static serial shift register of `SEG_LEN * NUM_SEG` stages, 64 by default. It is split into equal segments. A bit on the serial input enters the first stage on every rising clock edge and moves one stage further on each later edge. A tap sits at the last stage of every segment.

A single write-enable input sets the direction of the taps. With write enable low, every tap drives out the content of its stage. With write enable high, every tap is released to high impedance. Each tap except the last then becomes an input, and on the next rising edge its value goes into the first stage of the following segment. This lets software fill the four segments in parallel, one bit per segment per clock. The last tap only ever drives; whatever it holds is dropped off the end of the chain.

Each tap is modelled as three signals: a drive value, an output enable, and a sampled input. The surrounding logic resolves the bus.

Top module: `seg_shift_chain`

## Requirements
- R1: While `rst_n` is low, and from then until the first shifting edge after release, every stage holds 0, so every bit of `tap_out` reads 0.
- R2: On every rising edge after reset, `ser_in` is stored in stage 1. This happens whether `wr_en` is high or low.
- R3: On a rising edge with `wr_en` low, every stage from 2 up takes the previous value of the stage before it, including across segment boundaries. `tap_out[k]` always shows stage `SEG_LEN*(k+1)`.
- R4: `tap_oe` is all ones while `wr_en` is low and all zeros while `wr_en` is high. It follows `wr_en` at either clock level, without waiting for an edge.
- R5: On a rising edge with `wr_en` high, the first stage of segment k+1 (stage `SEG_LEN*(k+1)+1`) takes `tap_in[k]`, for k = 0 to `NUM_SEG-2`. It does not take the last stage of segment k.
- R6: The last tap has no input path. The content of the final stage is lost on each rising edge, for either level of `wr_en`.
- R7: Inside a segment, stages shift on every rising edge, whatever the level of `wr_en`.
- R8: Stored data changes only on rising edges. A falling edge, or a clock held at either level, leaves `tap_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the chain moves on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_in | input | 1 | Serial data into stage 1 |
| wr_en | input | 1 | High: taps released and loading; low: taps drive |
| tap_in | input | NUM_SEG-1 | Values sampled from taps 0..NUM_SEG-2 while loading |
| tap_out | output | NUM_SEG | Content of the last stage of each segment |
| tap_oe | output | NUM_SEG | Per-tap drive enable, the inverse of wr_en |

## Verification
The bench builds the block with its default four segments of 16 stages. At that size, a single marked bit can be walked across every segment boundary and off the end of the chain within about seventy cycles. Three loading taps and one drive-only tap also give every loading pattern along with the unloadable last tap. Random mixes of `wr_en`, `tap_in` and serial data then hit boundary loads that land next to ordinary shifts. A 64-entry model in the bench predicts every tap after every edge.

// File: rtl/seg_shift_pkg.sv
package seg_shift_pkg;
  // Default geometry of the chain
  localparam int unsigned DEF_SEG_LEN = 16;
  localparam int unsigned DEF_NUM_SEG = 4;

  // Index (0-based) of the first stage of a segment
  function automatic int unsigned seg_head(input int unsigned seg, input int unsigned len);
    return seg * len;
  endfunction

  // Index (0-based) of the last stage of a segment, i.e. its tap point
  function automatic int unsigned seg_tail(input int unsigned seg, input int unsigned len);
    return seg * len + len - 1;
  endfunction
endpackage

// File: rtl/ss_rst_sync.sv
module ss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ss_segment.sv
module ss_segment #(
  parameter int unsigned LEN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           head_d,
  output logic [LEN-1:0] stage_q
);
  logic [LEN-1:0] stage_d;

  // Next state: head takes the selected entry bit, the rest move up by one
  always_comb begin
    stage_d = stage_q;
    if (adv) begin
      stage_d = {stage_q[LEN-2:0], head_d};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end
endmodule

// File: rtl/ss_entry_sel.sv
module ss_entry_sel #(
  parameter int unsigned NUM_SEG = 4
) (
  input  logic               wr_en,
  input  logic               ser_in,
  input  logic [NUM_SEG-2:0] tap_in,
  input  logic [NUM_SEG-1:0] tail_q,
  output logic [NUM_SEG-1:0] head_d
);
  // Segment 0 always takes the serial input; later segments pick
  // between the external tap value and the tail of the segment below.
  assign head_d[0] = ser_in;

  for (genvar k = 1; k < NUM_SEG; k++) begin : g_sel
    always_comb begin
      if (wr_en) begin
        head_d[k] = tap_in[k-1];
      end else begin
        head_d[k] = tail_q[k-1];
      end
    end
  end
endmodule

// File: rtl/seg_shift_chain.sv
module seg_shift_chain
  import seg_shift_pkg::*;
#(
  parameter int unsigned SEG_LEN = DEF_SEG_LEN,
  parameter int unsigned NUM_SEG = DEF_NUM_SEG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_in,
  input  logic               wr_en,
  input  logic [NUM_SEG-2:0] tap_in,
  output logic [NUM_SEG-1:0] tap_out,
  output logic [NUM_SEG-1:0] tap_oe
);
  localparam int unsigned DEPTH = SEG_LEN * NUM_SEG;

  logic               core_rst_n;
  logic               adv;
  logic [NUM_SEG-1:0] head_d;
  logic [NUM_SEG-1:0] tail_q;
  logic [DEPTH-1:0]   chain;

  ss_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  // The chain moves on every rising edge; written out as an explicit enable
  assign adv = 1'b1;

  ss_entry_sel #(.NUM_SEG(NUM_SEG)) u_sel (
    .wr_en  (wr_en),
    .ser_in (ser_in),
    .tap_in (tap_in),
    .tail_q (tail_q),
    .head_d (head_d)
  );

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    logic [SEG_LEN-1:0] seg_q;

    ss_segment #(.LEN(SEG_LEN)) u_seg (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .adv     (adv),
      .head_d  (head_d[k]),
      .stage_q (seg_q)
    );

    assign chain[seg_tail(k, SEG_LEN):seg_head(k, SEG_LEN)] = seg_q;
    assign tail_q[k]  = seg_q[SEG_LEN-1];
    assign tap_out[k] = seg_q[SEG_LEN-1];
    assign tap_oe[k]  = ~wr_en;
  end
endmodule

// File: rtl/seg_shift_chain_chk.sv
module seg_shift_chain_chk #(
  parameter int unsigned SEG_LEN = 16,
  parameter int unsigned NUM_SEG = 4
) (
  input logic                       clk,
  input logic                       core_rst_n,
  input logic                       ser_in,
  input logic                       wr_en,
  input logic [NUM_SEG-2:0]         tap_in,
  input logic [NUM_SEG-1:0]         tap_oe,
  input logic [SEG_LEN*NUM_SEG-1:0] chain
);
  // R4: enables are the inverse of write enable at every edge
  a_r4_oe_tracks_we: assert property (@(posedge clk) disable iff (!core_rst_n)
    tap_oe == {NUM_SEG{~wr_en}});

  // R2: stage 1 captures the serial input
  a_r2_head_capture: assert property (@(posedge clk) disable iff (!core_rst_n)
    1'b1 |=> chain[0] == $past(ser_in));

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_in
    for (genvar i = 1; i < SEG_LEN; i++) begin : g_st
      // R7: inside a segment stages move regardless of write enable
      a_r7_inner_shift: assert property (@(posedge clk) disable iff (!core_rst_n)
        1'b1 |=> chain[k*SEG_LEN+i] == $past(chain[k*SEG_LEN+i-1]));
    end
  end

  for (genvar k = 1; k < NUM_SEG; k++) begin : g_bd
    // R3: with write enable low a boundary stage follows its predecessor
    a_r3_boundary_shift: assert property (@(posedge clk) disable iff (!core_rst_n)
      !wr_en |=> chain[k*SEG_LEN] == $past(chain[k*SEG_LEN-1]));
    // R5: with write enable high a boundary stage takes the tap input
    a_r5_boundary_load: assert property (@(posedge clk) disable iff (!core_rst_n)
      wr_en |=> chain[k*SEG_LEN] == $past(tap_in[k-1]));
  end
endmodule

bind seg_shift_chain seg_shift_chain_chk #(
  .SEG_LEN(SEG_LEN),
  .NUM_SEG(NUM_SEG)
) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .ser_in     (ser_in),
  .wr_en      (wr_en),
  .tap_in     (tap_in),
  .tap_oe     (tap_oe),
  .chain      (chain)
);

// File: tb/seg_shift_chain_test.sv
`timescale 1ns/1ps
module seg_shift_chain_test;
  localparam int L = 16;
  localparam int N = 4;
  localparam int D = L * N;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ser_in;
  logic         wr_en;
  logic [N-2:0] tap_in;
  logic [N-1:0] tap_out;
  logic [N-1:0] tap_oe;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic mdl [D];

  always #2 clk = ~clk;  // 250 MHz

  seg_shift_chain #(.SEG_LEN(L), .NUM_SEG(N)) uut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .wr_en(wr_en),
    .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_taps();
    logic [N-1:0] t;
    for (int k = 0; k < N; k++) t[k] = mdl[k*L+L-1];
    return t;
  endfunction

  function automatic logic [N-1:0] exp_oe(input logic w);
    return w ? '0 : '1;
  endfunction

  // Model of one rising edge built from R2, R3, R5, R6, R7
  task automatic mdl_edge(input logic s, input logic w, input logic [N-2:0] ti);
    for (int i = D-1; i > 0; i--) begin
      if (w && (i % L == 0)) mdl[i] = ti[i/L-1];
      else mdl[i] = mdl[i-1];
    end
    mdl[0] = s;
  endtask

  task automatic step(input logic s, input logic w, input logic [N-2:0] ti, input string tag);
    @(negedge clk);
    #1;
    chk(tap_out === exp_taps(), "R8 hold over falling edge", tap_out, exp_taps());
    ser_in = s; wr_en = w; tap_in = ti;
    #0.5;
    chk(tap_oe === exp_oe(w), "R4 enable with clock low", tap_oe, exp_oe(w));
    @(posedge clk);
    mdl_edge(s, w, ti);
    #1;
    chk(tap_out === exp_taps(), tag, tap_out, exp_taps());
    chk(tap_oe === exp_oe(w), "R4 enable with clock high", tap_oe, exp_oe(w));
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        done = 1'b1;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    rst_n = 1'b0; ser_in = 1'b0; wr_en = 1'b0; tap_in = '0;
    for (int i = 0; i < D; i++) mdl[i] = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk(tap_out === '0, "R1 reset clears taps", tap_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(tap_out === '0, "R1 cleared after release", tap_out, 0);

    // R2 R3: walk a single one through all segments and off the end (R6)
    step(1'b1, 1'b0, '0, "R2 walking bit enters");
    for (int c = 1; c < D + 2; c++) step(1'b0, 1'b0, '0, "R3 walking bit shift");
    chk(tap_out === '0, "R6 bit lost off the end", tap_out, 0);

    // R5: parallel load with taps released, distinct pattern per segment
    for (int c = 0; c < L; c++)
      step(c[0], 1'b1, (N-1)'(c % 7), "R5 segment load");
    // R7 with wr_en high already exercised; now R6: last tap drops data under load
    for (int c = 0; c < L; c++) step(1'b1, 1'b1, '1, "R6 R7 load ones");
    chk(tap_out === '1, "R5 all taps one", tap_out, '1);

    // R4: enable follows wr_en between edges (clock level held high)
    @(posedge clk); #0.5;
    wr_en = 1'b0; #0.2;
    chk(tap_oe === '1, "R4 mid-high drop of wr_en", tap_oe, '1);
    wr_en = 1'b1; #0.2;
    chk(tap_oe === '0, "R4 mid-high rise of wr_en", tap_oe, '0);
    @(negedge clk); wr_en = 1'b0;
    // that edge loaded with wr_en high using ones on taps and ser_in=1
    mdl_edge(1'b1, 1'b1, tap_in);

    // Constrained random mix
    for (int c = 0; c < 300; c++) begin
      logic w;
      w = (($urandom % 4) == 0);
      step(1'($urandom), w, (N-1)'($urandom), "R2 R3 R5 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule